// File: doc/BRIEF.md
# Integer ALU with Shifter

This block is the execute-stage arithmetic and logic unit of a simple load/store processor. It takes two data-wide operands, a shift count and a 4-bit operation code. It returns a data-wide result and a flag that is high when that result is all zeros. The flag feeds branch-on-equal style decisions.

The unit adds and subtracts with silent wrap-around. It computes bitwise AND, OR and NOR, and a signed less-than that returns 0 or 1. It also performs zero-filling left and right shifts and places an upper immediate. The caller sign- or zero-extends any instruction immediate before it reaches the operands, so masking with an immediate is just AND or OR against a zero-extended B operand. By default the result and flag are registered, which gives one clock of latency. Setting `OUT_REG` to 0 makes the unit purely combinational.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 returns A + B modulo 2^32, with no exception on carry or overflow.
- R2: Operation code 1 returns A - B modulo 2^32, with no exception on borrow or overflow.
- R3: Operation code 2 returns A AND B and code 3 returns A OR B, bit by bit. With a zero-extended 16-bit B this masks or sets only the low 16 bits of A.
- R4: Operation code 4 returns NOT (A OR B), so a zero B gives the complement of A.
- R5: Operation code 5 treats A and B as two's-complement signed values. It returns 1 in bit 0 when A < B and 0 otherwise, and bits 31..1 are always zero. The answer is correct when A and B have opposite signs, including cases where A - B overflows.
- R6: Operation code 6 shifts A left by `shamt_i` (0..31) places and fills the vacated low bits with zeros.
- R7: Operation code 7 shifts A right by `shamt_i` places and fills the vacated high bits with zeros, even when A is negative.
- R8: Operation code 8 puts B[15:0] into result bits 31..16 and clears bits 15..0. B[31:16] has no effect.
- R9: `zero_o` is high exactly when all 32 result bits are zero.
- R10: Operation codes 9 to 15 return a result of zero whatever the operands are.
- R11: With `OUT_REG` = 1, the result and flag appear on the first rising clock edge after the inputs are applied and hold until the next edge. While `rst_n` is low, the result is 0 and `zero_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A; the shifted value for shifts |
| b_i | input | 32 | Operand B; its low 16 bits are the upper-immediate source |
| shamt_i | input | 5 | Shift count |
| result_o | output | 32 | Result |
| zero_o | output | 1 | High when the result is all zeros |

## Verification
The bound checker watches, on every clock, the properties that hold for any operands. The flag must agree with the result. A set-less-than result must be 0 or 1. An upper-immediate result must have clear low bits. Shifts by a non-zero count must have a zero-filled end bit. An unknown operation code must give a zero result.

Arithmetic values can only be shown by the bench's directed scenarios, which compare full results against values computed from the requirements. These include the carry and borrow wrap, the signed compare across opposite signs, and exact shift patterns. The same holds for masking, the NOR-as-NOT case, the one-cycle latency and the reset values.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_AND = 4'd2,
      OP_OR  = 4'd3,
      OP_NOR = 4'd4,
      OP_SLT = 4'd5,
      OP_SLL = 4'd6,
      OP_SRL = 4'd7,
      OP_LUI = 4'd8
   } alu_op_e;

   localparam int unsigned OP_LAST = 8;

endpackage

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              lt_o
);
   localparam int unsigned MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic              signs_differ;

   assign b_eff = sub_i ? ~b_i : b_i;
   // Carry-in of one completes the two's-complement negation of B.
   assign sum_o = a_i + b_eff + DATA_W'(sub_i);

   // Opposite signs: the negative operand is smaller, and the difference
   // is not consulted since it may have overflowed.
   assign signs_differ = a_i[MSB] ^ b_i[MSB];
   assign lt_o = signs_differ ? a_i[MSB] : sum_o[MSB];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
   import int_alu_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o
);
   logic [DATA_W-1:0] or_v;

   assign or_v = a_i | b_i;

   always_comb begin
      case (op_i)
         OP_AND:  res_o = a_i & b_i;
         OP_OR:   res_o = or_v;
         OP_NOR:  res_o = ~or_v;
         default: res_o = '0;
      endcase
   end
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0]  data_i,
   input  logic [SHAMT_W-1:0] shamt_i,
   input  logic               left_i,
   output logic [DATA_W-1:0]  data_o
);
   logic [DATA_W-1:0] stage [0:SHAMT_W];

   assign stage[0] = data_i;

   // Logarithmic barrel: stage k moves the word by 2**k when count bit k is set.
   for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
      localparam int unsigned DIST = 1 << k;
      logic [DATA_W-1:0] moved;
      assign moved = left_i ? (stage[k] << DIST) : (stage[k] >> DIST);
      assign stage[k+1] = shamt_i[k] ? moved : stage[k];
   end

   assign data_o = stage[SHAMT_W];
endmodule

// File: rtl/int_alu.sv
module int_alu
   import int_alu_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IMM_W   = 16,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned SHAMT_W = $clog2(DATA_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         op_i,
   input  logic [DATA_W-1:0]  a_i,
   input  logic [DATA_W-1:0]  b_i,
   input  logic [SHAMT_W-1:0] shamt_i,
   output logic [DATA_W-1:0]  result_o,
   output logic               zero_o
);
   localparam int unsigned LOW_W = DATA_W - IMM_W;

   if (DATA_W < 2 || (1 << SHAMT_W) != DATA_W) begin : g_bad_width
      $error("int_alu: DATA_W must be a power of two");
   end
   if (IMM_W == 0 || IMM_W >= DATA_W) begin : g_bad_imm
      $error("int_alu: IMM_W must lie between 1 and DATA_W-1");
   end

   alu_op_e           op;
   logic [DATA_W-1:0] sum_v;
   logic              lt_v;
   logic [DATA_W-1:0] logic_v;
   logic [DATA_W-1:0] shift_v;
   logic [DATA_W-1:0] res_next;
   logic              zero_next;

   assign op = alu_op_e'(op_i);

   alu_arith_unit #(.DATA_W(DATA_W)) u_arith (
      .a_i   (a_i),
      .b_i   (b_i),
      .sub_i (op == OP_SUB || op == OP_SLT),
      .sum_o (sum_v),
      .lt_o  (lt_v)
   );

   alu_logic_unit #(.DATA_W(DATA_W)) u_logic (
      .op_i  (op),
      .a_i   (a_i),
      .b_i   (b_i),
      .res_o (logic_v)
   );

   alu_shift_unit #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
      .data_i  (a_i),
      .shamt_i (shamt_i),
      .left_i  (op == OP_SLL),
      .data_o  (shift_v)
   );

   always_comb begin
      case (op)
         OP_ADD, OP_SUB:         res_next = sum_v;
         OP_AND, OP_OR, OP_NOR:  res_next = logic_v;
         OP_SLT:                 res_next = {{(DATA_W-1){1'b0}}, lt_v};
         OP_SLL, OP_SRL:         res_next = shift_v;
         OP_LUI:                 res_next = {b_i[IMM_W-1:0], {LOW_W{1'b0}}};
         default:                res_next = '0;
      endcase
   end

   assign zero_next = (res_next == '0);

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result_o <= '0;
            zero_o   <= 1'b1;
         end else begin
            result_o <= res_next;
            zero_o   <= zero_next;
         end
      end
   end else begin : g_comb_out
      assign result_o = res_next;
      assign zero_o   = zero_next;
   end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
   import int_alu_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IMM_W   = 16,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned SHAMT_W = $clog2(DATA_W)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [3:0]         op_i,
   input logic [SHAMT_W-1:0] shamt_i,
   input logic [DATA_W-1:0]  result_o,
   input logic               zero_o
);
   logic [3:0]         op_d;
   logic [SHAMT_W-1:0] sh_d;

   // Align the observed operation with the result it produced.
   if (OUT_REG) begin : g_delay
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            op_d <= 4'(OP_ADD);
            sh_d <= '0;
         end else begin
            op_d <= op_i;
            sh_d <= shamt_i;
         end
      end
   end else begin : g_direct
      assign op_d = op_i;
      assign sh_d = shamt_i;
   end

   AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      zero_o == (result_o == '0)); // R9

   AST_SLT_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_d == 4'(OP_SLT)) |-> (result_o[DATA_W-1:1] == '0)); // R5

   AST_UPPER_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (op_d == 4'(OP_LUI)) |-> (result_o[DATA_W-IMM_W-1:0] == '0)); // R8

   AST_UNKNOWN_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op_d > 4'(OP_LAST)) |-> (result_o == '0)); // R10

   AST_SLL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (op_d == 4'(OP_SLL) && sh_d != '0) |-> (result_o[0] == 1'b0)); // R6

   AST_SRL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (op_d == 4'(OP_SRL) && sh_d != '0) |-> (result_o[DATA_W-1] == 1'b0)); // R7
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OUT_REG(OUT_REG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_i     (op_i),
   .shamt_i  (shamt_i),
   .result_o (result_o),
   .zero_o   (zero_o)
);

// File: tb/int_alu_test.sv
`timescale 1ns/1ps
module int_alu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op = 4'd0;
   logic [31:0] a = '0;
   logic [31:0] b = '0;
   logic [4:0]  sh = '0;
   logic [31:0] result;
   logic        zero;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   int_alu uut (
      .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
      .shamt_i(sh), .result_o(result), .zero_o(zero)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Apply inputs at a falling edge; the result register loads at the next
   // rising edge, so outputs are sampled at the following falling edge.
   task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                        input logic [4:0] s);
      @(negedge clk);
      op = o; a = x; b = y; sh = s;
      @(negedge clk);
   endtask

   task automatic expect_res(input string tag, input logic [31:0] exp);
      check(tag, result, exp);
      check({tag, "/R9"}, {31'd0, zero}, {31'd0, exp == 32'd0});
   endtask

   task automatic t_reset;
      check("R11 reset result", result, 32'd0);
      check("R11 reset zero", {31'd0, zero}, 32'd1);
   endtask

   task automatic t_add;
      apply(4'd0, 32'd5, 32'd7, 5'd0);             expect_res("R1 add", 32'd12);
      apply(4'd0, 32'hFFFF_FFFF, 32'd1, 5'd0);     expect_res("R1 add wrap", 32'd0);
      apply(4'd0, 32'h7FFF_FFFF, 32'd1, 5'd0);     expect_res("R1 add ovf", 32'h8000_0000);
   endtask

   task automatic t_sub;
      apply(4'd1, 32'd3, 32'd5, 5'd0);             expect_res("R2 sub neg", 32'hFFFF_FFFE);
      apply(4'd1, 32'h8000_0000, 32'd1, 5'd0);     expect_res("R2 sub ovf", 32'h7FFF_FFFF);
      apply(4'd1, 32'd9, 32'd9, 5'd0);             expect_res("R2 sub equal", 32'd0);
   endtask

   task automatic t_logic;
      apply(4'd2, 32'h0000_0D0D, 32'h8000_0909, 5'd0); expect_res("R3 and", 32'h0000_0909);
      apply(4'd2, 32'hDEAD_BEEF, 32'h0000_00FF, 5'd0); expect_res("R3 and mask", 32'h0000_00EF);
      apply(4'd3, 32'hDEAD_0000, 32'h0000_1234, 5'd0); expect_res("R3 or", 32'hDEAD_1234);
   endtask

   task automatic t_nor;
      apply(4'd4, 32'h0000_0D0D, 32'h8000_0909, 5'd0); expect_res("R4 nor", 32'h7FFF_F2F2);
      apply(4'd4, 32'h1234_5678, 32'd0, 5'd0);         expect_res("R4 not", 32'hEDCB_A987);
      apply(4'd4, 32'hFFFF_0000, 32'h0000_FFFF, 5'd0); expect_res("R4 nor all", 32'd0);
   endtask

   task automatic t_slt;
      apply(4'd5, 32'hFFFF_FFFF, 32'd1, 5'd0);         expect_res("R5 neg<pos", 32'd1);
      apply(4'd5, 32'd1, 32'hFFFF_FFFF, 5'd0);         expect_res("R5 pos<neg", 32'd0);
      apply(4'd5, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0); expect_res("R5 ovf case", 32'd0);
      apply(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0); expect_res("R5 ovf case2", 32'd1);
      apply(4'd5, 32'd4, 32'd4, 5'd0);                 expect_res("R5 equal", 32'd0);
      apply(4'd5, 32'd3, 32'd4, 5'd0);                 expect_res("R5 small", 32'd1);
   endtask

   task automatic t_shift;
      apply(4'd6, 32'h0000_010F, 32'd0, 5'd4);     expect_res("R6 sll 4", 32'h0000_10F0);
      apply(4'd6, 32'hFFFF_FFFF, 32'd0, 5'd31);    expect_res("R6 sll 31", 32'h8000_0000);
      apply(4'd6, 32'hA5A5_A5A5, 32'd0, 5'd0);     expect_res("R6 sll 0", 32'hA5A5_A5A5);
      apply(4'd7, 32'h0000_10F0, 32'd0, 5'd2);     expect_res("R7 srl 2", 32'h0000_043C);
      apply(4'd7, 32'h8000_0000, 32'd0, 5'd31);    expect_res("R7 srl neg", 32'd1);
      apply(4'd7, 32'hF000_000F, 32'd0, 5'd4);     expect_res("R7 srl fill", 32'h0F00_0000);
   endtask

   task automatic t_lui;
      apply(4'd8, 32'hFFFF_FFFF, 32'h1234_ABCD, 5'd7); expect_res("R8 lui", 32'hABCD_0000);
      apply(4'd8, 32'd0, 32'hFFFF_0000, 5'd0);         expect_res("R8 lui zero", 32'd0);
   endtask

   task automatic t_bad_op;
      for (int k = 9; k < 16; k++) begin
         apply(4'(k), 32'hFFFF_FFFF, 32'h1234_5678, 5'd3);
         expect_res($sformatf("R10 op %0d", k), 32'd0);
      end
   endtask

   task automatic t_latency;
      apply(4'd0, 32'd100, 32'd23, 5'd0);
      expect_res("R11 first", 32'd123);
      @(negedge clk);
      op = 4'd1; a = 32'd50; b = 32'd8;
      #1;
      check("R11 hold before edge", result, 32'd123);
      @(negedge clk);
      expect_res("R11 after edge", 32'd42);
   endtask

   initial begin
      #800000;
      if (!done) begin
         fails++;
         $display("FAIL R11 watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_add();
      t_sub();
      t_logic();
      t_nor();
      t_slt();
      t_shift();
      t_lui();
      t_bad_op();
      t_latency();
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule